// File: doc/BRIEF.md
# ROM Size Mirror Detector

This block works out how large a byte-wide ROM is by looking for address aliasing. A small ROM that is wired into a larger address space shows up again at higher addresses. The block walks the first 64 byte offsets of the device. At each offset it reads the byte at the offset itself, then reads the same offset one megabyte higher and two megabytes higher. It compares each of those reads with the first byte.

There are two candidate sizes, 1 MB and 2 MB, and each has its own match counter. A counter only advances while every offset so far has matched for that candidate. Once a candidate fails, its reads are no longer issued. The scan ends early when the current offset equals neither counter. When the scan ends, a 2-bit size code and a done flag are presented and held until the next start.

The block drives a single request/acknowledge read port. The read address and request stay steady until the memory side acknowledges. Read data is taken in the acknowledge cycle.

Top module: `rom_mirror_sizer`

## Requirements
- R1: While reset is asserted (rst_n low) and after it is released, rd_req is 0, done is 0 and size_code is 2'b00.
- R2: A one-cycle start while idle or done begins a new scan. The first read of every scan is to address 0.
- R3: Once rd_req is raised, it stays high and rd_addr stays unchanged until a cycle with rd_ack high. rd_data is sampled in that cycle.
- R4: For each offset k, the block first reads address k. It then reads k+0x100000 if the 1 MB candidate is still alive, and then k+0x200000 if the 2 MB candidate is still alive. No address outside offsets 0..63 of the three 1 MB windows starting at 0, 0x100000 and 0x200000 is ever requested.
- R5: Each candidate counter starts at 0 on start. It increments by one only when its mirror byte equals the base byte while the counter equals the current offset. In every other case it holds.
- R6: The scan stops, with no further read, when the offset reaches 64 or when neither counter equals the current offset.
- R7: size_code is 2'b00 (1 MB) when the 1 MB counter ended at 64. Otherwise it is 2'b01 (2 MB) when the 2 MB counter ended at 64. Otherwise it is 2'b10 (4 MB).
- R8: done stays at 1 with rd_req at 0, and size_code stays stable, until the next start. A start received during a scan has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan (used when idle or done) |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | 22 | Byte address of the pending read |
| rd_ack | input | 1 | Read acknowledge; rd_data valid in this cycle |
| rd_data | input | 8 | Read data |
| size_code | output | 2 | 00 = 1 MB, 01 = 2 MB, 10 = 4 MB |
| done | output | 1 | Scan finished, result valid |

## Verification
Every read completes one clock after its acknowledge. There is one evaluation cycle between offsets. done rises one clock after the final evaluation, so the time to a result depends on the memory latency and on how early the scan stops. The bench therefore does not count a fixed number of cycles. It samples done at the falling edge of each cycle under a time limit. Once done is seen, it compares the size code, the number of acknowledged reads and the address history with values worked out by hand for each ROM image. The reads counted must equal the exact number the mirror rules call for, so an extra or missing read is caught even when the size code happens to be right.

// File: rtl/rms_pkg.sv
package rms_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_BASE,
    ST_MIR1,
    ST_MIR2,
    ST_DONE
  } rms_state_t;

  localparam logic [1:0] SZ_1MB = 2'b00;
  localparam logic [1:0] SZ_2MB = 2'b01;
  localparam logic [1:0] SZ_4MB = 2'b10;

  // Decide the size code from the final candidate counters.
  function automatic logic [1:0] size_decide(input int unsigned c1,
                                             input int unsigned c2,
                                             input int unsigned full);
    if (c1 == full)      return SZ_1MB;
    else if (c2 == full) return SZ_2MB;
    else                 return SZ_4MB;
  endfunction

  // Address of probe offset 'off' within window 'win' (0 = base).
  function automatic int unsigned probe_addr(input int unsigned off,
                                             input int unsigned win,
                                             input int unsigned step);
    return off + win * step;
  endfunction

endpackage

// File: rtl/rms_tracker.sv
module rms_tracker #(
  parameter int PROBE_LEN = 64,
  parameter int DATA_W    = 8,
  localparam int CNT_W    = $clog2(PROBE_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [CNT_W-1:0]  offset,
  input  logic              cmp_valid,
  input  logic [DATA_W-1:0] base_byte,
  input  logic [DATA_W-1:0] mirror_byte,
  output logic [CNT_W-1:0]  count,
  output logic              alive
);

  logic bump;

  assign alive = (count == offset);
  assign bump  = cmp_valid && (mirror_byte == base_byte);

  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (clear)  count <= '0;
    else if (bump)   count <= count + 1'b1;
  end

  // R5: a match advances the counter by exactly one
  a_r5_bump_step: assert property (@(posedge clk) disable iff (!rst_n)
    bump && !clear |=> count == CNT_W'($past(count) + 1));
  // R5: no compare, no clear -> counter holds
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bump && !clear |=> $stable(count));
  // R5: mirror reads are only compared while the candidate is unbroken
  a_r5_only_alive: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |-> alive);
  // R5: counter never passes the probe length
  a_r5_cap: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(PROBE_LEN));

endmodule

// File: rtl/rms_sequencer.sv
module rms_sequencer
  import rms_pkg::*;
#(
  parameter int ADDR_W      = 22,
  parameter int DATA_W      = 8,
  parameter int PROBE_LEN   = 64,
  parameter int MIRROR_STEP = 'h100000,
  localparam int CNT_W      = $clog2(PROBE_LEN + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  rd_ack,
  input  logic [DATA_W-1:0]     rd_data,
  input  logic [1:0]            alive,
  input  logic [1:0][CNT_W-1:0] counts,
  output logic                  rd_req,
  output logic [ADDR_W-1:0]     rd_addr,
  output logic [1:0]            cmp_valid,
  output logic                  clear,
  output logic [CNT_W-1:0]      offset,
  output logic [DATA_W-1:0]     base_q,
  output logic                  done,
  output logic [1:0]            size_code
);

  rms_state_t state;
  logic       scan_end;
  logic [1:0] win;

  assign clear    = start && (state == ST_IDLE || state == ST_DONE);
  assign scan_end = (offset == CNT_W'(PROBE_LEN)) || (alive == 2'b00);
  assign rd_req   = (state == ST_BASE) || (state == ST_MIR1) || (state == ST_MIR2);
  assign done     = (state == ST_DONE);
  assign cmp_valid[0] = (state == ST_MIR1) && rd_ack;
  assign cmp_valid[1] = (state == ST_MIR2) && rd_ack;

  always_comb begin
    case (state)
      ST_MIR1: win = 2'd1;
      ST_MIR2: win = 2'd2;
      default: win = 2'd0;
    endcase
  end

  assign rd_addr = ADDR_W'(probe_addr(int'(offset), int'(win), MIRROR_STEP));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      offset    <= '0;
      base_q    <= '0;
      size_code <= SZ_1MB;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: if (start) begin
          state  <= ST_CHECK;
          offset <= '0;
        end
        ST_CHECK: begin
          if (scan_end) begin
            state     <= ST_DONE;
            size_code <= size_decide(int'(counts[0]), int'(counts[1]), PROBE_LEN);
          end else begin
            state <= ST_BASE;
          end
        end
        ST_BASE: if (rd_ack) begin
          base_q <= rd_data;
          state  <= alive[0] ? ST_MIR1 : ST_MIR2;
        end
        ST_MIR1: if (rd_ack) begin
          if (alive[1]) begin
            state <= ST_MIR2;
          end else begin
            state  <= ST_CHECK;
            offset <= offset + 1'b1;
          end
        end
        ST_MIR2: if (rd_ack) begin
          state  <= ST_CHECK;
          offset <= offset + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: request and address held until acknowledged
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));
  // R4: only offsets inside the probe window are requested
  a_r4_window: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr & ADDR_W'(MIRROR_STEP - 1)) < ADDR_W'(PROBE_LEN));
  // R6: no read once the scan has finished
  a_r6_quiet_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req);
  // R8: result and flag hold until the next start
  a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(size_code));

endmodule

// File: rtl/rom_mirror_sizer.sv
module rom_mirror_sizer #(
  parameter int ADDR_W      = 22,
  parameter int DATA_W      = 8,
  parameter int PROBE_LEN   = 64,
  parameter int MIRROR_STEP = 'h100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  output logic [1:0]        size_code,
  output logic              done
);

  localparam int CNT_W  = $clog2(PROBE_LEN + 1);
  localparam int N_CAND = 2;

  logic [N_CAND-1:0]            alive;
  logic [N_CAND-1:0]            cmp_valid;
  logic [N_CAND-1:0][CNT_W-1:0] counts;
  logic                         clear;
  logic [CNT_W-1:0]             offset;
  logic [DATA_W-1:0]            base_q;

  rms_sequencer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PROBE_LEN(PROBE_LEN), .MIRROR_STEP(MIRROR_STEP)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rd_ack(rd_ack), .rd_data(rd_data),
    .alive(alive), .counts(counts),
    .rd_req(rd_req), .rd_addr(rd_addr),
    .cmp_valid(cmp_valid), .clear(clear),
    .offset(offset), .base_q(base_q),
    .done(done), .size_code(size_code)
  );

  for (genvar g = 0; g < N_CAND; g++) begin : g_cand
    rms_tracker #(.PROBE_LEN(PROBE_LEN), .DATA_W(DATA_W)) u_trk (
      .clk(clk), .rst_n(rst_n), .clear(clear),
      .offset(offset), .cmp_valid(cmp_valid[g]),
      .base_byte(base_q), .mirror_byte(rd_data),
      .count(counts[g]), .alive(alive[g])
    );
  end

endmodule

// File: tb/test_rom_mirror_sizer.sv
module test_rom_mirror_sizer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rd_req;
  logic [21:0] rd_addr;
  logic        rd_ack = 1'b0;
  logic [7:0]  rd_data = 8'h00;
  logic [1:0]  size_code;
  logic        done;

  always #2.5 clk = ~clk;   // 200 MHz

  rom_mirror_sizer i_rom_mirror_sizer (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_data(rd_data),
    .size_code(size_code), .done(done)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // ROM image model
  int unsigned rom_bytes  = 'h100000;
  bit          corrupt_en = 0;
  int unsigned corrupt_at = 0;
  int          lat        = 0;
  int          wait_cnt   = 0;
  int          reads      = 0;
  int          bad_addr   = 0;
  int          first_addr = -1;

  function automatic logic [7:0] rom_byte(input int unsigned a);
    int unsigned b;
    logic [7:0] v;
    b = a % rom_bytes;
    v = b[7:0] ^ b[15:8] ^ {b[21:16], 2'b00};
    if (corrupt_en && a == corrupt_at) v = v ^ 8'hA5;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      rd_ack   <= 1'b0;
      wait_cnt <= 0;
    end else begin
      rd_ack <= 1'b0;
      if (rd_req && !rd_ack) begin
        if (wait_cnt >= lat) begin
          rd_ack   <= 1'b1;
          rd_data  <= rom_byte(int'(rd_addr));
          wait_cnt <= 0;
          if (first_addr < 0) first_addr <= int'(rd_addr);
          reads <= reads + 1;
          if ((rd_addr & 22'hFFFFF) >= 22'd64 || rd_addr[21:20] == 2'd3)
            bad_addr <= bad_addr + 1;
        end else begin
          wait_cnt <= wait_cnt + 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    reads = 0; bad_addr = 0; first_addr = -1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      if (done) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic [31:0] rom;
    logic        cen;
    logic [31:0] cat;
    logic [3:0]  lat;
    logic [1:0]  exp_size;
    logic [15:0] exp_reads;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{32'h100000, 1'b0, 32'h0,      4'd0, 2'b00, 16'd192}, // full mirror at 1 MB
    '{32'h200000, 1'b0, 32'h0,      4'd1, 2'b01, 16'd129}, // 2 MB part
    '{32'h400000, 1'b0, 32'h0,      4'd0, 2'b10, 16'd3},   // no mirror
    '{32'h100000, 1'b1, 32'h100005, 4'd2, 2'b01, 16'd134}, // 1 MB copy broken at 5
    '{32'h100000, 1'b1, 32'h20003F, 4'd0, 2'b00, 16'd192}, // 2 MB copy broken, 1 MB wins
    '{32'h200000, 1'b1, 32'h20000A, 4'd0, 2'b10, 16'd23},  // both broken, early stop
    '{32'h100000, 1'b1, 32'h0,      4'd3, 2'b10, 16'd3},   // base byte broken
    '{32'h100000, 1'b1, 32'h10003F, 4'd1, 2'b01, 16'd192}  // 1 MB broken at last offset
  };

  initial begin
    bit ok;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(rd_req == 1'b0, "R1", "rd_req in reset", rd_req, 0);
    check(done == 1'b0, "R1", "done in reset", done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(size_code == 2'b00 && !done && !rd_req, "R1", "idle after reset",
          int'(size_code), 0);

    for (int v = 0; v < NV; v++) begin
      rom_bytes  = TBL[v].rom;
      corrupt_en = TBL[v].cen;
      corrupt_at = TBL[v].cat;
      lat        = int'(TBL[v].lat);
      pulse_start();
      wait_done(ok);
      check(ok, "R6", $sformatf("vec %0d finished", v), ok, 1);
      check(size_code == TBL[v].exp_size, "R7",
            $sformatf("vec %0d size_code", v), size_code, TBL[v].exp_size);
      check(reads == int'(TBL[v].exp_reads), "R4",
            $sformatf("vec %0d read count (R5/R6)", v), reads, TBL[v].exp_reads);
      check(bad_addr == 0, "R4", $sformatf("vec %0d out-of-window reads", v),
            bad_addr, 0);
      check(first_addr == 0, "R2", $sformatf("vec %0d first address", v),
            first_addr, 0);
    end

    // R8: result and done held while idle after a scan
    begin
      logic [1:0] held;
      int extra;
      held  = size_code;
      extra = reads;
      repeat (20) @(negedge clk);
      check(done && size_code == held, "R8", "done/size held", int'(size_code), int'(held));
      check(reads == extra && !rd_req, "R8", "no reads after done", reads, extra);
    end

    // R8: start during a busy scan is ignored (1 MB image, 192 reads)
    rom_bytes = 'h100000; corrupt_en = 0; lat = 1;
    pulse_start();
    repeat (40) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    check(ok && reads == 192, "R8", "busy start ignored, reads", reads, 192);
    check(size_code == 2'b00, "R8", "busy start ignored, size", size_code, 0);

    // R3: with a long latency the result is unchanged (requests wait for ack)
    rom_bytes = 'h200000; lat = 6;
    pulse_start();
    wait_done(ok);
    check(ok && size_code == 2'b01 && reads == 129, "R3", "slow memory 2 MB",
          reads, 129);

    // R1: reset in the middle of a scan returns to the reset state
    rom_bytes = 'h100000; lat = 0;
    pulse_start();
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(!rd_req && !done && size_code == 2'b00, "R1", "mid-scan reset",
          int'(size_code), 0);
    rst_n = 1'b1;

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule